// File: doc/BRIEF.md
# Digital Supply Fault Detector

This block watches a single power rail through a stream of digitised voltage codes. Each code arrives with a valid strobe. The block compares the code with a programmable low limit and a programmable high limit. A two-bit selector arms the low-side check, the high-side check, or both together, which gives window supervision. A fault is reported only after it has persisted for a programmable number of samples. Once a fault is reported, it stays set until the code has moved back past its limit by a programmable hysteresis margin.

The same channel can be switched to logic mode instead. In that mode it stops acting as a supervisor and passes a synchronised copy of a digital input pin. All fault reporting is forced low while in logic mode. Range scaling and conversion happen upstream of this block.

Top module: `supply_fault_monitor`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `uv_flag`, `ov_flag`, `fault` and `logic_level` are all 0. Reset also clears both qualification counters.
- R2: `fault_sel` bit 0 arms the low-side check and bit 1 arms the high-side check. The encodings are 01 for low only, 10 for high only, 11 for window and 00 for none. A side that is not armed has its status bit cleared on the next clock, and it ignores every sample.
- R3: The low-side condition is true on a valid sample whose code is strictly below `uv_thr`. A code equal to `uv_thr` is not a fault.
- R4: The high-side condition is true on a valid sample whose code is strictly above `ov_thr`. A code equal to `ov_thr` is not a fault.
- R5: With `glitch_len` = N, a status bit sets on the clock after the (N+1)-th consecutive valid sample that meets its condition, so N = 0 sets on the first such sample. A valid sample that does not meet the condition restarts the count. Cycles with `samp_valid` low neither count nor restart.
- R6: A set `uv_flag` clears on the clock after a valid sample with code > `uv_thr` + `hyst`. The sum is formed without wrap-around, so the flag never clears when the sum exceeds full scale. The clear is not filtered.
- R7: A set `ov_flag` clears on the clock after a valid sample with code + `hyst` < `ov_thr`. This is evaluated without wrap-around, so the flag never clears when `hyst` > `ov_thr`. The clear is not filtered.
- R8: A set status bit holds while samples lie in the hysteresis band. The hysteresis margin plays no part while the bit is clear.
- R9: `fault` is high exactly when `uv_flag` or `ov_flag` is high, with no added delay.
- R10: When `mode_logic` is 1, `uv_flag`, `ov_flag` and `fault` go to 0 on the next clock and stay 0, and both counters are cleared. `logic_level` then follows `logic_in` with a delay of two clocks. When `mode_logic` is 0, `logic_level` is 0.
- R11: In window mode the two sides qualify and release independently. `uv_flag` and `ov_flag` each report which limit was crossed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_logic | input | 1 | 1 = logic-input mode, 0 = supervisor mode |
| logic_in | input | 1 | Asynchronous digital level used in logic mode |
| samp_code | input | CODE_W | Voltage sample code |
| samp_valid | input | 1 | Qualifies `samp_code` for one cycle |
| uv_thr | input | CODE_W | Low-side limit |
| ov_thr | input | CODE_W | High-side limit |
| hyst | input | CODE_W | Release margin applied inward from each limit |
| fault_sel | input | 2 | Side arming: bit 0 low, bit 1 high |
| glitch_len | input | GLITCH_W | Extra consecutive samples required before a fault is reported |
| uv_flag | output | 1 | Low-side status |
| ov_flag | output | 1 | High-side status |
| fault | output | 1 | Either side reported |
| logic_level | output | 1 | Synchronised `logic_in` in logic mode |

## Verification
The bench keeps the defaults CODE_W = 8, GLITCH_W = 4 and SYNC_STAGES = 2. With 8-bit codes, limits near either end of the scale can be combined with a large margin, which reaches the no-wrap release cases of R6 and R7. A 4-bit filter length of 2 is short enough that a gated cycle and a restart can both be placed inside one qualification run. With the two-stage synchroniser, the exact cycle in which the logic level appears can be checked.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_LOW  = 2'b01,
    SEL_HIGH = 2'b10,
    SEL_WIN  = 2'b11
  } fault_sel_e;

  localparam int SIDE_LOW  = 0;
  localparam int SIDE_HIGH = 1;
  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/sfd_compare.sv
// Limit comparator for one side; IS_HIGH picks the direction.
module sfd_compare #(
  parameter int CODE_W  = 8,
  parameter bit IS_HIGH = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] limit,
  input  logic [CODE_W-1:0] margin,
  output logic              trip,
  output logic              release_ok
);
  localparam int EXT_W = CODE_W + 1;

  logic [EXT_W-1:0] code_x, limit_x, margin_x;
  assign code_x   = {1'b0, code};
  assign limit_x  = {1'b0, limit};
  assign margin_x = {1'b0, margin};

  generate
    if (IS_HIGH) begin : g_high
      assign trip       = code > limit;
      assign release_ok = (code_x + margin_x) < limit_x;
    end else begin : g_low
      assign trip       = code < limit;
      assign release_ok = code_x > (limit_x + margin_x);
    end
  endgenerate
endmodule

// File: rtl/sfd_qualify.sv
// Glitch qualification on set, immediate release.
module sfd_qualify #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             valid,
  input  logic             trip,
  input  logic             release_ok,
  input  logic [CNT_W-1:0] limit,
  output logic             flag
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      flag    <= 1'b0;
      run_cnt <= '0;
    end else if (valid) begin
      if (flag) begin
        run_cnt <= '0;
        if (release_ok) flag <= 1'b0;
      end else if (trip) begin
        if (run_cnt == limit) begin
          flag    <= 1'b1;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + ONE;
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/sfd_sync.sv
module sfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/supply_fault_monitor.sv
module supply_fault_monitor #(
  parameter int CODE_W      = 8,
  parameter int GLITCH_W    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_logic,
  input  logic                logic_in,
  input  logic [CODE_W-1:0]   samp_code,
  input  logic                samp_valid,
  input  logic [CODE_W-1:0]   uv_thr,
  input  logic [CODE_W-1:0]   ov_thr,
  input  logic [CODE_W-1:0]   hyst,
  input  logic [1:0]          fault_sel,
  input  logic [GLITCH_W-1:0] glitch_len,
  output logic                uv_flag,
  output logic                ov_flag,
  output logic                fault,
  output logic                logic_level
);
  import sfd_pkg::*;

  logic [CODE_W-1:0]    side_limit [NUM_SIDES];
  logic [NUM_SIDES-1:0] side_trip, side_rel, side_en, side_flag;
  logic                 sync_q;

  assign side_limit[SIDE_LOW]  = uv_thr;
  assign side_limit[SIDE_HIGH] = ov_thr;

  generate
    for (genvar gi = 0; gi < NUM_SIDES; gi++) begin : g_side
      assign side_en[gi] = fault_sel[gi] & ~mode_logic;

      sfd_compare #(.CODE_W(CODE_W), .IS_HIGH(gi == SIDE_HIGH)) u_cmp (
        .code       (samp_code),
        .limit      (side_limit[gi]),
        .margin     (hyst),
        .trip       (side_trip[gi]),
        .release_ok (side_rel[gi])
      );

      sfd_qualify #(.CNT_W(GLITCH_W)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .enable     (side_en[gi]),
        .valid      (samp_valid),
        .trip       (side_trip[gi]),
        .release_ok (side_rel[gi]),
        .limit      (glitch_len),
        .flag       (side_flag[gi])
      );
    end
  endgenerate

  sfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (logic_in),
    .q   (sync_q)
  );

  assign uv_flag     = side_flag[SIDE_LOW];
  assign ov_flag     = side_flag[SIDE_HIGH];
  assign fault       = |side_flag;
  assign logic_level = sync_q & mode_logic;
endmodule

// File: rtl/supply_fault_monitor_chk.sv
module supply_fault_monitor_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_logic,
  input logic [CODE_W-1:0] samp_code,
  input logic              samp_valid,
  input logic [CODE_W-1:0] uv_thr,
  input logic [CODE_W-1:0] ov_thr,
  input logic [CODE_W-1:0] hyst,
  input logic [1:0]        fault_sel,
  input logic              uv_flag,
  input logic              ov_flag,
  input logic              fault
);
  logic uv_rel, ov_rel;
  assign uv_rel = {1'b0, samp_code} > ({1'b0, uv_thr} + {1'b0, hyst});
  assign ov_rel = ({1'b0, samp_code} + {1'b0, hyst}) < {1'b0, ov_thr};

  // R10
  logic_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mode_logic |=> (!uv_flag && !ov_flag));

  // R2
  high_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_sel[1] |=> !ov_flag);

  // R3
  low_set_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (!uv_flag && !(samp_valid && samp_code < uv_thr)) |=> !uv_flag);

  // R4
  high_set_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (!ov_flag && !(samp_valid && samp_code > ov_thr)) |=> !ov_flag);

  // R6
  low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_flag && fault_sel[0] && !mode_logic && !(samp_valid && uv_rel)) |=> uv_flag);

  // R7
  high_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ov_flag && fault_sel[1] && !mode_logic && !(samp_valid && ov_rel)) |=> ov_flag);

  // R5
  gated_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!samp_valid && fault_sel[0] && !mode_logic) |=> $stable(uv_flag));

  // R9
  fault_or_chk: assert property (@(posedge clk) disable iff (rst)
    fault == (uv_flag || ov_flag));
endmodule

bind supply_fault_monitor supply_fault_monitor_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_logic (mode_logic),
  .samp_code  (samp_code),
  .samp_valid (samp_valid),
  .uv_thr     (uv_thr),
  .ov_thr     (ov_thr),
  .hyst       (hyst),
  .fault_sel  (fault_sel),
  .uv_flag    (uv_flag),
  .ov_flag    (ov_flag),
  .fault      (fault)
);

// File: tb/supply_fault_monitor_test.sv
module supply_fault_monitor_test;
  localparam int CODE_W   = 8;
  localparam int GLITCH_W = 4;
  localparam int NVEC     = 27;

  logic clk = 1'b0;
  logic rst, mode_logic, logic_in, samp_valid;
  logic [CODE_W-1:0]   samp_code, uv_thr, ov_thr, hyst;
  logic [1:0]          fault_sel;
  logic [GLITCH_W-1:0] glitch_len;
  logic uv_flag, ov_flag, fault, logic_level;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  supply_fault_monitor #(.CODE_W(CODE_W), .GLITCH_W(GLITCH_W)) uut (
    .clk(clk), .rst(rst), .mode_logic(mode_logic), .logic_in(logic_in),
    .samp_code(samp_code), .samp_valid(samp_valid), .uv_thr(uv_thr),
    .ov_thr(ov_thr), .hyst(hyst), .fault_sel(fault_sel),
    .glitch_len(glitch_len), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .fault(fault), .logic_level(logic_level)
  );

  // {sel[2], glitch[4], code[8], valid, exp_uv, exp_ov}; uv 0x40, ov 0xC0, hyst 8
  localparam logic [16:0] VEC [NVEC] = '{
    {2'b11, 4'd0, 8'h80, 1'b1, 1'b0, 1'b0},  // R11 in band
    {2'b11, 4'd0, 8'h40, 1'b1, 1'b0, 1'b0},  // R3 equal
    {2'b11, 4'd0, 8'h3F, 1'b1, 1'b1, 1'b0},  // R3 below, R5 N=0
    {2'b11, 4'd0, 8'h48, 1'b1, 1'b1, 1'b0},  // R8 band hold
    {2'b11, 4'd0, 8'h49, 1'b1, 1'b0, 1'b0},  // R6 release
    {2'b11, 4'd0, 8'hC0, 1'b1, 1'b0, 1'b0},  // R4 equal
    {2'b11, 4'd0, 8'hC1, 1'b1, 1'b0, 1'b1},  // R4 above
    {2'b11, 4'd0, 8'hB8, 1'b1, 1'b0, 1'b1},  // R8 band hold
    {2'b11, 4'd0, 8'hB7, 1'b1, 1'b0, 1'b0},  // R7 release
    {2'b01, 4'd0, 8'hFF, 1'b1, 1'b0, 1'b0},  // R2 high disarmed
    {2'b01, 4'd0, 8'h10, 1'b1, 1'b1, 1'b0},  // R2 low armed
    {2'b10, 4'd0, 8'h10, 1'b1, 1'b0, 1'b0},  // R2 low disarmed clears
    {2'b10, 4'd0, 8'hF0, 1'b1, 1'b0, 1'b1},  // R2 high armed
    {2'b00, 4'd0, 8'hF0, 1'b1, 1'b0, 1'b0},  // R2 none
    {2'b11, 4'd0, 8'h10, 1'b0, 1'b0, 1'b0},  // R5 no strobe
    {2'b11, 4'd2, 8'h10, 1'b1, 1'b0, 1'b0},  // R5 count 1
    {2'b11, 4'd2, 8'h10, 1'b0, 1'b0, 1'b0},  // R5 gap holds count
    {2'b11, 4'd2, 8'h10, 1'b1, 1'b0, 1'b0},  // R5 count 2
    {2'b11, 4'd2, 8'h10, 1'b1, 1'b1, 1'b0},  // R5 third sample sets
    {2'b11, 4'd2, 8'h80, 1'b1, 1'b0, 1'b0},  // R6 unfiltered clear
    {2'b11, 4'd2, 8'h10, 1'b1, 1'b0, 1'b0},  // R5 count 1
    {2'b11, 4'd2, 8'h80, 1'b1, 1'b0, 1'b0},  // R5 restart
    {2'b11, 4'd2, 8'h10, 1'b1, 1'b0, 1'b0},  // R5 count 1
    {2'b11, 4'd2, 8'h10, 1'b1, 1'b0, 1'b0},  // R5 count 2
    {2'b11, 4'd2, 8'hF0, 1'b1, 1'b0, 1'b0},  // R11 sides independent
    {2'b11, 4'd2, 8'hF0, 1'b1, 1'b0, 1'b0},  // R11 high count 2
    {2'b11, 4'd2, 8'hF0, 1'b1, 1'b0, 1'b1}   // R11 high sets
  };

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {uv,ov,fault,level} actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [CODE_W-1:0] code, input logic valid);
    @(negedge clk);
    samp_code  = code;
    samp_valid = valid;
    @(posedge clk);
    #1;
    samp_valid = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {uv_flag, ov_flag, fault, logic_level};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; mode_logic = 1'b0; logic_in = 1'b0; samp_valid = 1'b0;
    samp_code = '0; uv_thr = 8'h40; ov_thr = 8'hC0; hyst = 8'h08;
    fault_sel = 2'b11; glitch_len = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", outs(), 4'b0000);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", outs(), 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      fault_sel  = VEC[i][16:15];
      glitch_len = VEC[i][14:11];
      step(VEC[i][10:3], VEC[i][2]);
      check($sformatf("R3-R11 vector %0d", i), outs(),
            {VEC[i][1], VEC[i][0], VEC[i][1] | VEC[i][0], 1'b0});
    end

    // R10: logic mode suppresses a set fault and passes the level
    glitch_len = '0;
    step(8'h10, 1'b1);
    check("R10 pre fault", outs(), 4'b1010);
    @(negedge clk); mode_logic = 1'b1; logic_in = 1'b1;
    @(posedge clk); #1;
    check("R10 flags drop, level one stage", outs(), 4'b0000);
    @(posedge clk); #1;
    check("R10 level after two clocks", outs(), 4'b0001);
    step(8'h00, 1'b1);
    check("R10 sample ignored", outs(), 4'b0001);
    @(negedge clk); mode_logic = 1'b0;
    #1;
    check("R10 level gated off", outs(), 4'b0000);
    @(negedge clk); logic_in = 1'b0;

    // R6: sum beyond full scale never releases
    uv_thr = 8'hF8; hyst = 8'h10; fault_sel = 2'b01;
    step(8'h20, 1'b1);
    check("R6 no-wrap set", outs(), 4'b1010);
    step(8'hFF, 1'b1);
    check("R6 no-wrap hold", outs(), 4'b1010);

    // R7: margin above limit never releases
    ov_thr = 8'h04; fault_sel = 2'b10;
    step(8'h80, 1'b1);
    check("R7 no-wrap set", outs(), 4'b0110);
    step(8'h00, 1'b1);
    check("R7 no-wrap hold", outs(), 4'b0110);

    // R1: reset while faulted
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset clears", outs(), 4'b0000);
    @(negedge clk); rst = 1'b0;
    step(8'h80, 1'b1);
    check("R1 counter cleared, one sample sets N=0", outs(), 4'b0110);

    finish_run();
  end
endmodule